// File: doc/BRIEF.md
# Card Socket Control and Status Register

This block is a single 16-bit memory-mapped register that sits beside a removable-card socket. Software uses it for four things. It turns the socket interface on, and separately turns on the card-detect and voltage-sense inputs, which otherwise stay off as surge protection. It switches the card supply and allows the supply to be cut automatically when a card leaves the socket. It enables an interrupt that reports card insertion or removal. Finally, it reads back the live socket pins, each group shown only while its enable conditions hold.

Every raw socket pin passes through a two-flop synchroniser before any logic uses it. The supply-control output comes from a software-owned bit in the register. An automatic override can force that output low while a card is absent. The override does not touch the stored bit, so supply returns by itself when a card is inserted again. A sticky change flag records any card-detect edge seen while the detect inputs are enabled. The group interrupt output is that flag gated by its enable. Writing a one to the flag's bit position clears it.

Top module: `sockSlotReg`

## Requirements
- R1: After synchronous reset the register reads 0x0080: automatic power disable (bit 7) is 1; supply bit 13, detect enable bit 6, interface enable bit 5, interrupt enable bit 4 and the change flag bit 14 are 0. `sockPwr` and `grpIrq` are 0.
- R2: Bits 13, 7, 6, 5 and 4 store the written value and read it back. Writes to bits 15, 12, 11:8 and 3:0 are ignored. Bits 15 and 12 always read 0.
- R3: Bits 11, 10, 9 and 8 read write-protect, ready, battery-detect-2 and battery-detect-1 (synchronised) only when bit 5 is 1 and both active-low card-detect inputs are 0. Otherwise they read 0.
- R4: Bits 3, 2, 1 and 0 read card-detect-2, card-detect-1, voltage-sense-2 and voltage-sense-1 (synchronised) only when bits 5 and 6 are both 1. Otherwise they read 0.
- R5: A socket pin change first shows in the readback after the second rising clock edge, not after the first.
- R6: `sockPwr` equals bit 13 AND NOT (bit 7 AND bit 6 AND either synchronised card-detect input high). While bit 6 is 0, the detect inputs cannot cut the supply.
- R7: The automatic override never changes stored bit 13. It reads 1 while the output is forced low, and the output returns high when the card-detect inputs go back to 00.
- R8: Bit 14 is a sticky change flag. It sets one clock after a synchronised card-detect edge while bit 6 is 1. Edges while bit 6 is 0 never set it.
- R9: Writing 1 to bit 14 clears the flag. Writing 0 there leaves it unchanged.
- R10: `grpIrq` equals the change flag AND bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read value |
| sockWp | input | 1 | Raw write-protect pin |
| sockRdy | input | 1 | Raw ready pin |
| sockBvd2 | input | 1 | Raw battery-detect-2 pin |
| sockBvd1 | input | 1 | Raw battery-detect-1 pin |
| sockCdN | input | 2 | Raw active-low card-detect pins, [1] = detect 2 |
| sockVsN | input | 2 | Raw active-low voltage-sense pins, [1] = sense 2 |
| sockPwr | output | 1 | Card supply enable |
| grpIrq | output | 1 | Group interrupt |

## Verification
The bench goes after the two different mirror conditions. A design that gated the status pins on the detect enable, or gated the detect pins on card presence, returns wrong bits in one of the two groups. It removes a card while auto-disable is on and then reads bit 13. A design that cleared the stored supply bit would read 0 there and fail to restore supply on reinsertion. It also samples the readback one edge and two edges after a pin change, which catches a missing or extra synchroniser stage. It toggles card-detect with the detect inputs off, which catches a change flag that ignores surge protection. It writes 0 to the flag bit, which catches a clear that fires on any write.

// File: rtl/sockRegPkg.sv
package sockRegPkg;

  localparam int REG_W    = 16;
  localparam int STAT_W   = 4;
  localparam int CD_W     = 2;
  localparam int VS_W     = 2;
  localparam int PIN_W    = STAT_W + CD_W + VS_W;
  localparam int SYNC_LEN = 2;

  localparam int CHG_BIT      = 14;
  localparam int SW_PWR_BIT   = 13;
  localparam int RSVD_BIT     = 12;
  localparam int STAT_LSB     = 8;
  localparam int AUTO_PWR_BIT = 7;
  localparam int DET_EN_BIT   = 6;
  localparam int IF_EN_BIT    = 5;
  localparam int IRQ_EN_BIT   = 4;
  localparam int DET_LSB      = 0;

  localparam logic [REG_W-1:0] WR_MASK =
    (REG_W'(1) << CHG_BIT) | (REG_W'(1) << SW_PWR_BIT) |
    (REG_W'(1) << AUTO_PWR_BIT) | (REG_W'(1) << DET_EN_BIT) |
    (REG_W'(1) << IF_EN_BIT) | (REG_W'(1) << IRQ_EN_BIT);

  typedef struct packed {
    logic swPwr;
    logic autoPwr;
    logic detEn;
    logic ifEn;
    logic irqEn;
  } sockCfgT;

  typedef struct packed {
    logic wrCfg;
    logic clrChg;
  } sockStrobeT;

  localparam sockCfgT CFG_RESET = '{swPwr: 1'b0, autoPwr: 1'b1, detEn: 1'b0,
                                    ifEn: 1'b0, irqEn: 1'b0};

endpackage

// File: rtl/sockSync.sv
module sockSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sockRegCtrl.sv
module sockRegCtrl
  import sockRegPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             regWe,
  input  logic [REG_W-1:0] regWdata,
  output sockCfgT          cfg,
  output sockStrobeT       strobe
);

  logic [REG_W-1:0] wrVal;

  assign wrVal = regWdata & WR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RESET;
    end else if (regWe) begin
      cfg <= '{swPwr:   wrVal[SW_PWR_BIT],
               autoPwr: wrVal[AUTO_PWR_BIT],
               detEn:   wrVal[DET_EN_BIT],
               ifEn:    wrVal[IF_EN_BIT],
               irqEn:   wrVal[IRQ_EN_BIT]};
    end
  end

  always_comb begin
    strobe.wrCfg  = regWe;
    strobe.clrChg = regWe & wrVal[CHG_BIT];
  end

  // R7
  sw_pwr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !regWe |=> $stable(cfg.swPwr));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !regWe |=> $stable(cfg));

endmodule

// File: rtl/sockRegData.sv
module sockRegData
  import sockRegPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  sockCfgT          cfg,
  input  sockStrobeT       strobe,
  input  logic [PIN_W-1:0] pinsRaw,
  output logic [REG_W-1:0] regRdata,
  output logic             sockPwr,
  output logic             grpIrq
);

  logic [PIN_W-1:0]  pinsSync;
  logic [STAT_W-1:0] statSync;
  logic [CD_W-1:0]   cdSync;
  logic [VS_W-1:0]   vsSync;
  logic [CD_W-1:0]   cdPrev;
  logic              chgEdge;
  logic              chgFlag;
  logic              cardGone;
  logic              pwrCut;

  sockSync #(.WIDTH(PIN_W), .STAGES(SYNC_LEN)) uSync (
    .clk  (clk),
    .rst  (rst),
    .din  (pinsRaw),
    .dout (pinsSync)
  );

  assign statSync = pinsSync[PIN_W-1 -: STAT_W];
  assign cdSync   = pinsSync[VS_W +: CD_W];
  assign vsSync   = pinsSync[0 +: VS_W];

  always_ff @(posedge clk) begin
    if (rst) cdPrev <= '0;
    else     cdPrev <= cdSync;
  end

  assign chgEdge = cfg.detEn && (cdSync != cdPrev);

  always_ff @(posedge clk) begin
    if (rst)                chgFlag <= 1'b0;
    else if (chgEdge)       chgFlag <= 1'b1;
    else if (strobe.clrChg) chgFlag <= 1'b0;
  end

  assign cardGone = |cdSync;
  assign pwrCut   = cfg.autoPwr && cfg.detEn && cardGone;
  assign sockPwr  = cfg.swPwr && !pwrCut;
  assign grpIrq   = chgFlag && cfg.irqEn;

  always_comb begin
    regRdata               = '0;
    regRdata[CHG_BIT]      = chgFlag;
    regRdata[SW_PWR_BIT]   = cfg.swPwr;
    regRdata[AUTO_PWR_BIT] = cfg.autoPwr;
    regRdata[DET_EN_BIT]   = cfg.detEn;
    regRdata[IF_EN_BIT]    = cfg.ifEn;
    regRdata[IRQ_EN_BIT]   = cfg.irqEn;
    if (cfg.ifEn && (cdSync == '0))
      regRdata[STAT_LSB +: STAT_W] = statSync;
    if (cfg.ifEn && cfg.detEn)
      regRdata[DET_LSB +: CD_W+VS_W] = {cdSync, vsSync};
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !regRdata[REG_W-1] && !regRdata[RSVD_BIT]);

  // R6
  pwr_cut_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.autoPwr && cfg.detEn && cardGone) |-> !sockPwr);

  // R6
  pwr_needs_sw_chk: assert property (@(posedge clk) disable iff (rst)
    sockPwr |-> cfg.swPwr);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    grpIrq |-> (cfg.irqEn && chgFlag));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrChg && !chgEdge) |=> !chgFlag);

  // R8
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.detEn && !chgFlag) |=> !chgFlag);

  // R3
  stat_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.ifEn || cardGone) |-> (regRdata[STAT_LSB +: STAT_W] == '0));

endmodule

// File: rtl/sockSlotReg.sv
module sockSlotReg
  import sockRegPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        regWe,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        sockWp,
  input  logic        sockRdy,
  input  logic        sockBvd2,
  input  logic        sockBvd1,
  input  logic [1:0]  sockCdN,
  input  logic [1:0]  sockVsN,
  output logic        sockPwr,
  output logic        grpIrq
);

  sockCfgT          cfg;
  sockStrobeT       strobe;
  logic [PIN_W-1:0] pinsRaw;

  assign pinsRaw = {sockWp, sockRdy, sockBvd2, sockBvd1, sockCdN, sockVsN};

  sockRegCtrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .regWe    (regWe),
    .regWdata (regWdata),
    .cfg      (cfg),
    .strobe   (strobe)
  );

  sockRegData uData (
    .clk      (clk),
    .rst      (rst),
    .cfg      (cfg),
    .strobe   (strobe),
    .pinsRaw  (pinsRaw),
    .regRdata (regRdata),
    .sockPwr  (sockPwr),
    .grpIrq   (grpIrq)
  );

endmodule

// File: tb/sim_sockSlotReg.sv
`timescale 1ns/1ps
module sim_sockSlotReg;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        sockWp = 1'b0, sockRdy = 1'b0, sockBvd2 = 1'b0, sockBvd1 = 1'b0;
  logic [1:0]  sockCdN = 2'b11;
  logic [1:0]  sockVsN = 2'b00;
  logic        sockPwr, grpIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #4 clk = ~clk;

  sockSlotReg u0 (
    .clk(clk), .rst(rst), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .sockWp(sockWp), .sockRdy(sockRdy), .sockBvd2(sockBvd2), .sockBvd1(sockBvd1),
    .sockCdN(sockCdN), .sockVsN(sockVsN), .sockPwr(sockPwr), .grpIrq(grpIrq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1;
    regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
    regWdata = '0;
  endtask

  task automatic testReset;
    chk("R1 read", regRdata, 16'h0080);
    chk("R1 pwr", {15'd0, sockPwr}, 16'd0);
    chk("R1 irq", {15'd0, grpIrq}, 16'd0);
  endtask

  task automatic testReadback;
    doWrite(16'hFFFF);
    chk("R2 all ones", regRdata, 16'h20FC);
    doWrite(16'h0000);
    chk("R2 all zeros", regRdata, 16'h0000);
    doWrite(16'h9F0F);
    chk("R2 ro bits ignored", regRdata, 16'h0000);
  endtask

  task automatic testStatus;
    doWrite(16'h0020);
    @(negedge clk);
    sockCdN = 2'b00; sockWp = 1'b1; sockRdy = 1'b0; sockBvd2 = 1'b1; sockBvd1 = 1'b1;
    waitN(3);
    chk("R3 present", regRdata, 16'h0B20);
    sockCdN = 2'b01;
    waitN(3);
    chk("R3 cd high", regRdata, 16'h0020);
    sockCdN = 2'b00;
    waitN(3);
    doWrite(16'h0000);
    chk("R3 if off", regRdata, 16'h0000);
  endtask

  task automatic testDetect;
    @(negedge clk);
    sockCdN = 2'b10; sockVsN = 2'b01;
    waitN(3);
    doWrite(16'h0060);
    chk("R4 both en", regRdata, 16'h0069);
    doWrite(16'h0040);
    chk("R4 if off", regRdata, 16'h0040);
    doWrite(16'h0020);
    chk("R4 det off", regRdata, 16'h0020);
  endtask

  task automatic testSync;
    doWrite(16'h0060);
    sockVsN = 2'b10;
    @(negedge clk);
    chk("R5 one edge", regRdata, 16'h0069);
    @(negedge clk);
    chk("R5 two edges", regRdata, 16'h006A);
  endtask

  task automatic testPower;
    doWrite(16'h20C0);
    chk("R6 cut", {15'd0, sockPwr}, 16'd0);
    chk("R7 bit kept", regRdata, 16'h20C0);
    sockCdN = 2'b00;
    waitN(2);
    chk("R7 restored", {15'd0, sockPwr}, 16'd1);
    sockCdN = 2'b01;
    waitN(2);
    chk("R6 removed", {15'd0, sockPwr}, 16'd0);
    chk("R7 bit13", regRdata & 16'h2000, 16'h2000);
    doWrite(16'h6040);
    chk("R6 auto off", {15'd0, sockPwr}, 16'd1);
    doWrite(16'h2080);
    chk("R6 det off", {15'd0, sockPwr}, 16'd1);
    doWrite(16'h0080);
    chk("R6 sw off", {15'd0, sockPwr}, 16'd0);
  endtask

  task automatic testFlag;
    doWrite(16'h4050);
    chk("R9 cleared", regRdata & 16'h4000, 16'h0000);
    chk("R10 idle", {15'd0, grpIrq}, 16'd0);
    sockCdN = 2'b00;
    waitN(4);
    chk("R8 set", regRdata & 16'h4000, 16'h4000);
    chk("R10 raised", {15'd0, grpIrq}, 16'd1);
    doWrite(16'h0050);
    chk("R9 write zero", regRdata & 16'h4000, 16'h4000);
    doWrite(16'h0040);
    chk("R10 masked", {15'd0, grpIrq}, 16'd0);
    doWrite(16'h4040);
    chk("R9 clear", regRdata & 16'h4000, 16'h0000);
    doWrite(16'h0000);
    sockCdN = 2'b11;
    waitN(4);
    chk("R8 det off", regRdata & 16'h4000, 16'h0000);
    doWrite(16'h0040);
    waitN(2);
    chk("R8 no stale", regRdata & 16'h4000, 16'h0000);
  endtask

  initial begin
    waitN(4);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testReadback();
    testStatus();
    testDetect();
    testSync();
    testPower();
    testFlag();
    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule